// File: doc/BRIEF.md
# E3 Overhead Bit Insertion Port

This block sits on the transmit side of an E3 framer that builds the 56-bit overhead section of each frame one bit at a time. For every overhead bit slot the framer offers, the block raises a strobe towards external terminal logic. On the first slot of a frame it also raises a frame marker. Alongside these it gives the slot's position, byte and bit index. The terminal logic counts strobes from the frame marker, so it always knows which overhead bit is current.

When the terminal logic wants to supply its own value for the current bit, it raises an insert request and presents the value, both in the strobe cycle. The block checks the position against a fixed permission mask. The two framing bytes and the error-monitor byte (positions 0 to 23) are never overwritten. The trail-trace, maintenance, operator and general-purpose bytes (positions 24 to 55) accept the terminal's bit.

The chosen bit goes back to the framer one clock after the strobe. It comes with a valid pulse and an accept or refuse indication.

Top module: `e3oh_insert_port`

## Requirements
- R1: While reset is held and on the first clock after it, `tx_valid`, `tx_bit`, `ins_ack` and `ins_nak` are all 0.
- R2: `oh_strobe` equals `fr_slot` and `oh_frame` equals `fr_first` in the same cycle.
- R3: In a slot cycle with `fr_first` high, `oh_pos` is 0. Each later slot without `fr_first` shows a position one higher than the previous slot.
- R4: `fr_first` high without a slot resets the count, so the next slot shows position 0. A new `fr_first` in mid-frame restarts at 0, whatever the count was.
- R5: After position 55, further slots without `fr_first` show position 56, byte code 7, bit index 0, and refuse insertion.
- R6: For a position below 56, `oh_byte` is the position divided by 8 and `oh_bitidx` is the position modulo 8. Bit index 0 is the byte's most significant bit, sent first. Byte codes: 0 first framing, 1 second framing, 2 error monitor, 3 trail trace, 4 maintenance, 5 operator, 6 general channel.
- R7: A slot at position 24 to 55 with `term_ins_req` high gives, on the next clock, `tx_valid`=1, `tx_bit`=`term_ins_bit`, `ins_ack`=1 and `ins_nak`=0.
- R8: A slot at position 0 to 23 or 56 with `term_ins_req` high gives, on the next clock, `tx_valid`=1, `tx_bit`=`fr_bit`, `ins_nak`=1 and `ins_ack`=0.
- R9: A slot without a request gives, on the next clock, `tx_valid`=1, `tx_bit`=`fr_bit`, and both indications 0.
- R10: After a cycle with no slot, `tx_valid`, `ins_ack` and `ins_nak` are 0 and `tx_bit` keeps its value, whatever `term_ins_req` and `term_ins_bit` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_slot | input | 1 | Framer offers an overhead bit slot this cycle |
| fr_first | input | 1 | Framer marks the first overhead slot of a frame |
| fr_bit | input | 1 | Framer's own overhead bit for the slot |
| term_ins_req | input | 1 | Terminal asks to replace the current bit |
| term_ins_bit | input | 1 | Terminal's replacement bit |
| oh_strobe | output | 1 | Overhead slot strobe to the terminal |
| oh_frame | output | 1 | Frame marker to the terminal |
| oh_pos | output | 6 | Current overhead position (56 = past frame end) |
| oh_byte | output | 3 | Overhead byte code of the position |
| oh_bitidx | output | 3 | Bit within the byte, 0 = most significant |
| tx_valid | output | 1 | Registered bit for the framer is valid |
| tx_bit | output | 1 | Overhead bit returned to the framer |
| ins_ack | output | 1 | Insertion was accepted |
| ins_nak | output | 1 | Insertion was refused |

## Verification
The bench builds the block with its default parameters: seven overhead bytes, of which the first three are locked. One frame is therefore only 56 slots. Every position, on both sides of the 23/24 lock boundary and past the frame end, is swept many times with random framer bits, random requests and random idle gaps. Extra runs cover frame restarts in mid-frame, with and without a slot.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;

  // Overhead byte codes, in transmission order within a frame.
  typedef enum logic [2:0] {
    OHB_FRAME_A = 3'd0,
    OHB_FRAME_B = 3'd1,
    OHB_ERRMON  = 3'd2,
    OHB_TRACE   = 3'd3,
    OHB_MAINT   = 3'd4,
    OHB_OPER    = 3'd5,
    OHB_GENCH   = 3'd6,
    OHB_NONE    = 3'd7
  } oh_byte_e;

  // Next count after a slot: one step forward, held at the past-end value.
  function automatic int unsigned next_count(input int unsigned cur,
                                             input int unsigned num_pos);
    if (cur >= num_pos) return num_pos;
    return cur + 1;
  endfunction

  // A position may be overwritten when it lies between the lock boundary and
  // the frame end.
  function automatic logic pos_open(input int unsigned pos,
                                    input int unsigned first_open,
                                    input int unsigned num_pos);
    return (pos >= first_open) && (pos < num_pos);
  endfunction

  // Byte number of a position, MSB-first bit order inside each byte.
  function automatic int unsigned pos_byte(input int unsigned pos,
                                           input int unsigned num_pos,
                                           input int unsigned num_bytes);
    if (pos >= num_pos) return num_bytes;
    return pos / 8;
  endfunction

  function automatic int unsigned pos_bit(input int unsigned pos,
                                          input int unsigned num_pos);
    if (pos >= num_pos) return 0;
    return pos % 8;
  endfunction

endpackage

// File: rtl/e3oh_slot_tracker.sv
module e3oh_slot_tracker #(
  parameter int unsigned NUM_POS = 56,
  parameter int unsigned PW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot,
  input  logic          first,
  output logic [PW-1:0] cur_pos
);
  import e3oh_pkg::*;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          restart_ev;
  logic          step_ev;

  assign restart_ev = first;
  assign step_ev    = slot && !first;

  // Position of the slot seen this cycle.
  assign cur_pos = restart_ev ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_ev)   cnt_d = slot ? PW'(1) : '0;
    else if (step_ev) cnt_d = PW'(next_count(int'(cnt_q), NUM_POS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= NUM_POS); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && int'(cnt_q) < NUM_POS) |=> (int'(cnt_q) == int'($past(cnt_q)) + 1)); // R3

  AST_CNT_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && int'(cnt_q) == NUM_POS) |=> $stable(cnt_q)); // R5

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (first && !slot) |=> (cnt_q == '0)); // R4

  AST_FRAME_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (first && slot) |=> (int'(cnt_q) == 1)); // R3

endmodule

// File: rtl/e3oh_pos_decode.sv
module e3oh_pos_decode #(
  parameter int unsigned NUM_BYTES  = 7,
  parameter int unsigned LOCK_BYTES = 3,
  parameter int unsigned PW         = 6,
  parameter int unsigned BW         = 3
) (
  input  logic [PW-1:0] pos,
  output logic [BW-1:0] byte_code,
  output logic [2:0]    bit_idx,
  output logic          permit
);
  import e3oh_pkg::*;

  localparam int unsigned NUM_POS    = NUM_BYTES * 8;
  localparam int unsigned FIRST_OPEN = LOCK_BYTES * 8;
  localparam int unsigned TBL        = 1 << PW;

  logic [TBL-1:0] open_mask;

  // Fixed per-position permission mask, one entry per reachable count value.
  for (genvar g = 0; g < TBL; g++) begin : g_mask
    assign open_mask[g] = pos_open(g, FIRST_OPEN, NUM_POS);
  end

  assign permit    = open_mask[pos];
  assign byte_code = BW'(pos_byte(int'(pos), NUM_POS, NUM_BYTES));
  assign bit_idx   = 3'(pos_bit(int'(pos), NUM_POS));

  always_comb begin
    AST_LOCKED_LOW: assert (!(permit && int'(pos) < FIRST_OPEN)); // R8
    AST_BYTE_RANGE: assert (int'(byte_code) <= NUM_BYTES);       // R6
  end

endmodule

// File: rtl/e3oh_ins_mux.sv
module e3oh_ins_mux #(
  parameter int unsigned NUM_POS    = 56,
  parameter int unsigned FIRST_OPEN = 24,
  parameter int unsigned PW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot,
  input  logic [PW-1:0] pos,
  input  logic          permit,
  input  logic          fr_bit,
  input  logic          req,
  input  logic          req_bit,
  output logic          tx_valid,
  output logic          tx_bit,
  output logic          ack,
  output logic          nak
);
  logic take_ev;
  logic refuse_ev;
  logic sel_bit;

  assign take_ev   = slot && req && permit;
  assign refuse_ev = slot && req && !permit;
  assign sel_bit   = take_ev ? req_bit : fr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_bit   <= 1'b0;
      ack      <= 1'b0;
      nak      <= 1'b0;
    end else begin
      tx_valid <= slot;
      ack      <= take_ev;
      nak      <= refuse_ev;
      if (slot) tx_bit <= sel_bit;
    end
  end

  AST_ACK_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (int'($past(pos)) >= FIRST_OPEN && int'($past(pos)) < NUM_POS)); // R7

  AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nak)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot) |-> (!tx_valid && !ack && !nak)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> $stable(tx_bit)); // R10

  AST_FRAMER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !ack) |-> (tx_bit == $past(fr_bit))); // R9

endmodule

// File: rtl/e3oh_insert_port.sv
module e3oh_insert_port #(
  parameter int unsigned NUM_BYTES  = 7,
  parameter int unsigned LOCK_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fr_slot,
  input  logic       fr_first,
  input  logic       fr_bit,
  input  logic       term_ins_req,
  input  logic       term_ins_bit,
  output logic       oh_strobe,
  output logic       oh_frame,
  output logic [5:0] oh_pos,
  output logic [2:0] oh_byte,
  output logic [2:0] oh_bitidx,
  output logic       tx_valid,
  output logic       tx_bit,
  output logic       ins_ack,
  output logic       ins_nak
);
  localparam int unsigned NUM_POS    = NUM_BYTES * 8;
  localparam int unsigned FIRST_OPEN = LOCK_BYTES * 8;
  localparam int unsigned PW         = $clog2(NUM_POS + 1);
  localparam int unsigned BW         = $clog2(NUM_BYTES + 1);

  logic [PW-1:0] cur_pos;
  logic [BW-1:0] byte_code;
  logic [2:0]    bit_idx;
  logic          permit;

  assign oh_strobe = fr_slot;
  assign oh_frame  = fr_first;
  assign oh_pos    = 6'(cur_pos);
  assign oh_byte   = 3'(byte_code);
  assign oh_bitidx = bit_idx;

  e3oh_slot_tracker #(.NUM_POS(NUM_POS), .PW(PW)) u_track (
    .clk(clk), .rst_n(rst_n), .slot(fr_slot), .first(fr_first), .cur_pos(cur_pos)
  );

  e3oh_pos_decode #(.NUM_BYTES(NUM_BYTES), .LOCK_BYTES(LOCK_BYTES), .PW(PW), .BW(BW)) u_dec (
    .pos(cur_pos), .byte_code(byte_code), .bit_idx(bit_idx), .permit(permit)
  );

  e3oh_ins_mux #(.NUM_POS(NUM_POS), .FIRST_OPEN(FIRST_OPEN), .PW(PW)) u_mux (
    .clk(clk), .rst_n(rst_n), .slot(fr_slot), .pos(cur_pos), .permit(permit),
    .fr_bit(fr_bit), .req(term_ins_req), .req_bit(term_ins_bit),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .ack(ins_ack), .nak(ins_nak)
  );

  AST_PERMIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_slot && term_ins_req && int'(cur_pos) < FIRST_OPEN) |=> ins_nak); // R8

endmodule

// File: tb/tb_e3oh_insert_port.sv
module tb_e3oh_insert_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_slot = 0, fr_first = 0, fr_bit = 0, term_ins_req = 0, term_ins_bit = 0;
  logic oh_strobe, oh_frame, tx_valid, tx_bit, ins_ack, ins_nak;
  logic [5:0] oh_pos;
  logic [2:0] oh_byte, oh_bitidx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int cycles = 0;
  int m_cnt = 0;
  logic m_bit = 0;

  always #10 clk = ~clk;

  e3oh_insert_port dut (.*);

  task automatic chk(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check comb outputs, then registered ones.
  task automatic step(input logic s, input logic f, input logic b, input logic r, input logic rb);
    int p, ev, ea, en;
    fr_slot = s; fr_first = f; fr_bit = b; term_ins_req = r; term_ins_bit = rb;
    #1;
    p = f ? 0 : m_cnt;
    chk("R2", oh_strobe, s, "strobe");
    chk("R2", oh_frame, f, "frame");
    if (s) begin
      chk(f ? "R3" : (p == 56 ? "R5" : "R3"), oh_pos, p, "pos");
      chk(p == 56 ? "R5" : "R6", oh_byte, (p < 56) ? p / 8 : 7, "byte");
      chk(p == 56 ? "R5" : "R6", oh_bitidx, (p < 56) ? p % 8 : 0, "bitidx");
    end
    ev = s; ea = 0; en = 0;
    if (s) begin
      if (r && p >= 24 && p < 56) begin ea = 1; m_bit = rb; end
      else begin en = r; m_bit = b; end
    end
    if (f) m_cnt = s ? 1 : 0;
    else if (s) m_cnt = (m_cnt >= 56) ? 56 : m_cnt + 1;
    @(negedge clk);
    if (!s) begin
      chk("R10", tx_valid, 0, "valid idle");
      chk("R10", ins_ack + 2 * ins_nak, 0, "ack/nak idle");
      chk("R10", tx_bit, m_bit, "bit hold");
    end else if (!r) begin
      chk("R9", tx_valid, 1, "valid");
      chk("R9", tx_bit, m_bit, "framer bit");
      chk("R9", ins_ack + 2 * ins_nak, 0, "ack/nak");
    end else if (ea) begin
      chk("R7", tx_bit, m_bit, "inserted bit");
      chk("R7", ins_ack + 2 * ins_nak + 4 * tx_valid, 5, "ack");
    end else begin
      chk("R8", tx_bit, m_bit, "refused keeps framer bit");
      chk("R8", ins_ack + 2 * ins_nak + 4 * tx_valid, 6, "nak");
    end
  endtask

  task automatic rnd_frame(input int gap_pct, input int len);
    for (int i = 0; i < len; i++) begin
      while (($urandom % 100) < gap_pct)
        step(0, 0, 1'($urandom), 1'($urandom), 1'($urandom));
      step(1, i == 0, 1'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", tx_valid + tx_bit + ins_ack + ins_nak, 0, "in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", tx_valid + tx_bit + ins_ack + ins_nak, 0, "after reset");
    // Full sweeps, every position with request held high and low.
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 56; i++) step(1, i == 0, 1'(i), 1'(k), 1'(~i));
    for (int i = 0; i < 56; i++) step(1, i == 0, 1'(i >> 1), 1'b1, 1'(i));
    // Random frames, with and without idle gaps.
    for (int k = 0; k < 40; k++) rnd_frame((k % 2) ? 30 : 0, 56);
    // Overrun past the frame end.
    rnd_frame(0, 56);
    for (int i = 0; i < 6; i++) step(1, 0, 1'(i), 1'b1, 1'(~i)); // R5
    // Restart in mid-frame with a slot, and without one.
    rnd_frame(0, 40);
    step(1, 1, 1'b1, 1'b1, 1'b0); // R3
    rnd_frame(10, 30);
    step(0, 1, 1'b0, 1'b1, 1'b1); // R4
    rnd_frame(0, 56);
    // Idle cycles with requests toggling.
    for (int i = 0; i < 8; i++) step(0, 0, 1'(i), 1'b1, 1'(i));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule